// File: doc/BRIEF.md
# Saturating Byte Error Rate Counter

This block keeps a running estimate of how many bytes a channel damages. After the error corrector finishes each block, it presents a one-cycle report. A clean or repaired block adds its repaired byte count to a live counter. A block that could not be repaired, or that arrived while the stream was out of lock, adds a fixed penalty weight instead. The counter stops at its all-ones value, which a reader takes to mean overflow.

A host fetches the count as three bytes through a strobe and a byte index. The top byte also carries the lock status in its most significant bit. Reading the top byte freezes a snapshot, so the middle and low bytes always belong to the same value. Reading the low byte takes the reported amount out of the live counter. Updates that arrive while a read is in progress stay in the counter.

Top module: `ber_counter`

## Requirements
- R1: After reset the live count is zero, and `rd_data` is zero until the first read strobe.
- R2: A report with `blk_valid` high and both bad flags low adds `blk_fixed` (0 to `MAX_FIX`, default 8) to the count.
- R3: A report with `blk_uncorr` or `blk_unsync` high adds exactly `WEIGHT` (default 9), whatever the value of `blk_fixed`.
- R4: The count saturates at 2^CNT_W-1 and never wraps, where CNT_W = 3*BYTE_W-1.
- R5: A strobe places the selected byte on `rd_data` one clock later, and the byte holds until the next strobe. Index 0 gives {status, count[CNT_W-1:2*BYTE_W]}, index 1 gives count[2*BYTE_W-1:BYTE_W], index 2 gives count[BYTE_W-1:0], and index 3 gives zero.
- R6: `sw_clear` zeroes the count and drops any report in the same cycle.
- R7: The top bit of the index-0 byte is 1 when `sync_ok` is low at the strobe and 0 when it is high.
- R8: The index-1 and index-2 bytes come from the snapshot taken at the last index-0 read, even if reports arrive in between.
- R9: An index-2 read that follows an index-0 read subtracts the snapshot from the live count, so increments made since the snapshot remain. An index-2 read with no snapshot pending returns the live low byte and zeroes the count.
- R10: A block report that arrives in the same cycle as an index-2 read is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| sw_clear | input | 1 | Software reset pulse; zeroes the count |
| blk_valid | input | 1 | One-cycle block report strobe |
| blk_fixed | input | FIX_W | Number of bytes repaired in the block |
| blk_uncorr | input | 1 | Block could not be repaired |
| blk_unsync | input | 1 | Block arrived out of lock |
| sync_ok | input | 1 | Stream lock status (1 = locked) |
| rd_stb | input | 1 | Byte read strobe |
| rd_idx | input | 2 | Byte index: 0 top, 1 middle, 2 low |
| rd_data | output | BYTE_W | Byte returned by the last read |

## Verification
The bench builds the block with BYTE_W = 4. That makes the count 11 bits wide, so it reaches its ceiling of 2047 after a few hundred penalty blocks instead of close to a million, and both the clamp on a repaired-byte add and the hold at the ceiling are exercised. WEIGHT and MAX_FIX keep their defaults of 9 and 8, so the per-block arithmetic is the same as in the full-width build. The narrow bytes still split the count into three distinct fields, which is what the snapshot, subtract-on-read and same-cycle collision cases depend on.

// File: rtl/ber_counter_pkg.sv
package ber_counter_pkg;

    // Byte selector for host reads; the order is what the host relies on
    typedef enum logic [1:0] {
        RD_HI   = 2'd0,
        RD_MID  = 2'd1,
        RD_LO   = 2'd2,
        RD_NONE = 2'd3
    } rd_sel_e;

endpackage

// File: rtl/ber_accum.sv
module ber_accum #(
    parameter int CNT_W  = 23,
    parameter int FIX_W  = 4,
    parameter int WEIGHT = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             drain,
    input  logic [CNT_W-1:0] drain_val,
    input  logic             blk_valid,
    input  logic [FIX_W-1:0] blk_fixed,
    input  logic             blk_bad,
    output logic [CNT_W-1:0] cnt
);

    localparam int             SW   = CNT_W + 1;
    localparam logic [SW-1:0]  MAXW = {1'b0, {CNT_W{1'b1}}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } acc_t;

    acc_t          acc_d, acc_q;
    logic [SW-1:0] step;
    logic [SW-1:0] sum;

    always_comb begin
        acc_d = acc_q;
        step  = blk_bad ? SW'(WEIGHT) : SW'(blk_fixed);
        sum   = {1'b0, acc_q.cnt} + step;
        if (clr) begin
            acc_d.cnt = '0;
        end else if (drain) begin
            // snapshot never exceeds live value; guard anyway
            acc_d.cnt = (drain_val > acc_q.cnt) ? '0 : acc_q.cnt - drain_val;
        end else if (blk_valid) begin
            acc_d.cnt = (sum > MAXW) ? MAXW[CNT_W-1:0] : sum[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign cnt = acc_q.cnt;

endmodule

// File: rtl/ber_readout.sv
module ber_readout
    import ber_counter_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 3 * BYTE_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_clear,
    input  logic              rd_stb,
    input  logic [1:0]        rd_idx,
    input  logic              sync_ok,
    input  logic [CNT_W-1:0]  cnt,
    output logic [CNT_W-1:0]  shadow,
    output logic              armed,
    output logic [BYTE_W-1:0] rd_data
);

    typedef struct packed {
        logic [CNT_W-1:0]  shadow;
        logic              armed;
        logic [BYTE_W-1:0] rdata;
    } rdo_t;

    rdo_t    rdo_d, rdo_q;
    rd_sel_e sel;

    always_comb begin
        rdo_d = rdo_q;
        sel   = rd_sel_e'(rd_idx);
        if (rd_stb) begin
            case (sel)
                RD_HI: begin
                    rdo_d.shadow = cnt;
                    rdo_d.armed  = 1'b1;
                    rdo_d.rdata  = {~sync_ok, cnt[CNT_W-1:2*BYTE_W]};
                end
                RD_MID: rdo_d.rdata = rdo_q.shadow[2*BYTE_W-1:BYTE_W];
                RD_LO: begin
                    rdo_d.rdata = rdo_q.armed ? rdo_q.shadow[BYTE_W-1:0]
                                              : cnt[BYTE_W-1:0];
                    rdo_d.armed = 1'b0;
                end
                default: rdo_d.rdata = '0;
            endcase
        end
        if (sw_clear) begin
            rdo_d.shadow = '0;
            rdo_d.armed  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdo_q <= '0;
        else        rdo_q <= rdo_d;
    end

    assign shadow  = rdo_q.shadow;
    assign armed   = rdo_q.armed;
    assign rd_data = rdo_q.rdata;

endmodule

// File: rtl/ber_counter.sv
module ber_counter
    import ber_counter_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int WEIGHT  = 9,
    parameter int MAX_FIX = 8,
    parameter int FIX_W   = $clog2(MAX_FIX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_clear,
    input  logic              blk_valid,
    input  logic [FIX_W-1:0]  blk_fixed,
    input  logic              blk_uncorr,
    input  logic              blk_unsync,
    input  logic              sync_ok,
    input  logic              rd_stb,
    input  logic [1:0]        rd_idx,
    output logic [BYTE_W-1:0] rd_data
);

    localparam int CNT_W = 3 * BYTE_W - 1;

    logic [CNT_W-1:0] live_cnt;
    logic [CNT_W-1:0] shadow;
    logic             armed;
    logic             drain;
    logic [CNT_W-1:0] drain_val;

    // low-byte read closes a read sequence: remove what was reported
    assign drain     = rd_stb && (rd_sel_e'(rd_idx) == RD_LO);
    assign drain_val = armed ? shadow : live_cnt;

    ber_accum #(
        .CNT_W  (CNT_W),
        .FIX_W  (FIX_W),
        .WEIGHT (WEIGHT)
    ) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (sw_clear),
        .drain     (drain),
        .drain_val (drain_val),
        .blk_valid (blk_valid),
        .blk_fixed (blk_fixed),
        .blk_bad   (blk_uncorr | blk_unsync),
        .cnt       (live_cnt)
    );

    ber_readout #(
        .BYTE_W (BYTE_W),
        .CNT_W  (CNT_W)
    ) u_readout (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_clear (sw_clear),
        .rd_stb   (rd_stb),
        .rd_idx   (rd_idx),
        .sync_ok  (sync_ok),
        .cnt      (live_cnt),
        .shadow   (shadow),
        .armed    (armed),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/ber_counter_chk.sv
module ber_counter_chk #(
    parameter int BYTE_W  = 8,
    parameter int WEIGHT  = 9,
    parameter int MAX_FIX = 8,
    parameter int FIX_W   = 4,
    parameter int CNT_W   = 3 * BYTE_W - 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sw_clear,
    input logic              blk_valid,
    input logic [FIX_W-1:0]  blk_fixed,
    input logic              blk_uncorr,
    input logic              blk_unsync,
    input logic              sync_ok,
    input logic              rd_stb,
    input logic [1:0]        rd_idx,
    input logic [BYTE_W-1:0] rd_data,
    input logic [CNT_W-1:0]  live_cnt,
    input logic              armed
);

    localparam logic [CNT_W-1:0] MAXC = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] WC   = CNT_W'(WEIGHT);

    logic lo_rd;
    assign lo_rd = rd_stb && (rd_idx == 2'd2);

    p_fix_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        blk_valid |-> (int'(blk_fixed) <= MAX_FIX));

    p_bad_weight_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_valid && (blk_uncorr || blk_unsync) && !sw_clear && !lo_rd
         && live_cnt <= MAXC - WC)
        |=> live_cnt == $past(live_cnt) + WC);

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (live_cnt == MAXC && !sw_clear && !lo_rd) |=> live_cnt == MAXC);

    p_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_clear && !lo_rd) |=> live_cnt >= $past(live_cnt));

    p_sw_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sw_clear |=> live_cnt == '0);

    p_status_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && rd_idx == 2'd0) |=> rd_data[BYTE_W-1] == !$past(sync_ok));

    p_lo_unarmed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_rd && !armed) |=> live_cnt == '0);

    p_lo_drops_blk_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_rd && !sw_clear) |=> live_cnt <= $past(live_cnt));

endmodule

bind ber_counter ber_counter_chk #(
    .BYTE_W  (BYTE_W),
    .WEIGHT  (WEIGHT),
    .MAX_FIX (MAX_FIX),
    .FIX_W   (FIX_W),
    .CNT_W   (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_clear   (sw_clear),
    .blk_valid  (blk_valid),
    .blk_fixed  (blk_fixed),
    .blk_uncorr (blk_uncorr),
    .blk_unsync (blk_unsync),
    .sync_ok    (sync_ok),
    .rd_stb     (rd_stb),
    .rd_idx     (rd_idx),
    .rd_data    (rd_data),
    .live_cnt   (live_cnt),
    .armed      (armed)
);

// File: tb/tb_ber_counter.sv
module tb_ber_counter;

    localparam int CLK_PERIOD = 10;
    localparam int TB_B   = 4;
    localparam int TB_CW  = 3 * TB_B - 1;
    localparam int TB_W   = 9;
    localparam int TB_MF  = 8;
    localparam int TB_FW  = 4;
    localparam int TB_MAX = (1 << TB_CW) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sw_clear = 1'b0;
    logic              blk_valid = 1'b0;
    logic [TB_FW-1:0]  blk_fixed = '0;
    logic              blk_uncorr = 1'b0;
    logic              blk_unsync = 1'b0;
    logic              sync_ok = 1'b1;
    logic              rd_stb = 1'b0;
    logic [1:0]        rd_idx = 2'd0;
    logic [TB_B-1:0]   rd_data;

    int total = 0;
    int bad   = 0;
    int model = 0;
    bit done  = 1'b0;
    bit take  = 1'b0;

    typedef struct {
        logic [TB_B-1:0] val;
        int              tag;
    } exp_t;
    exp_t exq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ber_counter #(
        .BYTE_W  (TB_B),
        .WEIGHT  (TB_W),
        .MAX_FIX (TB_MF),
        .FIX_W   (TB_FW)
    ) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_clear   (sw_clear),
        .blk_valid  (blk_valid),
        .blk_fixed  (blk_fixed),
        .blk_uncorr (blk_uncorr),
        .blk_unsync (blk_unsync),
        .sync_ok    (sync_ok),
        .rd_stb     (rd_stb),
        .rd_idx     (rd_idx),
        .rd_data    (rd_data)
    );

    task automatic check(input int tag, input logic [TB_B-1:0] act,
                         input logic [TB_B-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: a strobe seen at a rising edge yields data by the next falling edge
    always @(posedge clk) take <= rd_stb;
    always @(negedge clk) begin
        if (take) begin
            if (exq.size() == 0) begin
                check(5, rd_data, 'x);
            end else begin
                exp_t e;
                e = exq.pop_front();
                check(e.tag, rd_data, e.val);
            end
        end
    end

    function automatic int add_sat(int a, int b);
        return (a + b > TB_MAX) ? TB_MAX : a + b;
    endfunction

    task automatic blk(input int fixed, input bit unc, input bit uns);
        blk_valid  = 1'b1;
        blk_fixed  = TB_FW'(fixed);
        blk_uncorr = unc;
        blk_unsync = uns;
        model = add_sat(model, (unc || uns) ? TB_W : fixed);
        @(negedge clk);
        blk_valid = 1'b0; blk_uncorr = 1'b0; blk_unsync = 1'b0; blk_fixed = '0;
    endtask

    task automatic rd(input int idx, input logic [TB_B-1:0] exp, input int tag);
        exp_t e;
        e.val = exp; e.tag = tag;
        exq.push_back(e);
        rd_stb = 1'b1;
        rd_idx = 2'(idx);
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic read_all(input int tag);
        logic [TB_CW-1:0] s;
        s = TB_CW'(model);
        rd(0, {~sync_ok, s[TB_CW-1:2*TB_B]}, tag);
        rd(1, s[2*TB_B-1:TB_B], tag);
        rd(2, s[TB_B-1:0], tag);
        model = model - int'(s);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(1, rd_data, '0);                // R1 reset output
        read_all(1);                          // R1 count zero after reset

        // R2: repaired-byte counts 0..8
        for (int k = 0; k <= TB_MF; k++) blk(k, 1'b0, 1'b0);
        read_all(2);                          // expect 36
        blk(3, 1'b0, 1'b0); blk(8, 1'b0, 1'b0);
        read_all(2);

        // R3: penalty weight ignores blk_fixed
        blk(5, 1'b1, 1'b0);
        read_all(3);
        blk(0, 1'b0, 1'b1); blk(8, 1'b1, 1'b1);
        read_all(3);

        // R7: status bit reflects lock loss
        sync_ok = 1'b0;
        blk(2, 1'b0, 1'b0);
        read_all(7);
        sync_ok = 1'b1;
        read_all(7);

        // R5: index 3 returns zero; data holds with no strobe
        blk(6, 1'b0, 1'b0);
        rd(3, '0, 5);
        @(negedge clk);
        check(5, rd_data, '0);
        read_all(5);

        // R4: saturation with repaired-byte clamp and penalty blocks
        for (int k = 0; k < 226; k++) blk(0, 1'b1, 1'b0);
        blk(8, 1'b0, 1'b0); blk(8, 1'b0, 1'b0);
        read_all(4);                          // expect 2047
        for (int k = 0; k < 240; k++) blk(0, 1'b0, 1'b1);
        blk(8, 1'b0, 1'b0);
        read_all(4);

        // R8 / R9: snapshot coherence and increments kept across the read
        for (int k = 0; k < 20; k++) blk(7, 1'b0, 1'b0);   // 140
        begin
            logic [TB_CW-1:0] s;
            s = TB_CW'(model);
            rd(0, {1'b0, s[TB_CW-1:2*TB_B]}, 8);
            blk(5, 1'b0, 1'b0);
            rd(1, s[2*TB_B-1:TB_B], 8);
            blk(0, 1'b1, 1'b0);
            rd(2, s[TB_B-1:0], 8);
            model = model - int'(s);
        end
        read_all(9);                          // expect 14 left

        // R9: low-byte read with no snapshot pending clears
        blk(4, 1'b0, 1'b0); blk(8, 1'b0, 1'b0);
        rd(2, TB_B'(model), 9);
        model = 0;
        read_all(9);

        // R10: report colliding with low-byte read is dropped
        blk(3, 1'b0, 1'b0);
        begin
            exp_t e;
            e.val = TB_B'(model); e.tag = 10;
            exq.push_back(e);
            rd_stb = 1'b1; rd_idx = 2'd2;
            blk_valid = 1'b1; blk_fixed = 4'd7;
            @(negedge clk);
            rd_stb = 1'b0; blk_valid = 1'b0; blk_fixed = '0;
            model = 0;
        end
        read_all(10);

        // R6: software clear, with a colliding report dropped
        blk(8, 1'b1, 1'b0); blk(5, 1'b0, 1'b0);
        sw_clear = 1'b1; blk_valid = 1'b1; blk_fixed = 4'd6;
        @(negedge clk);
        sw_clear = 1'b0; blk_valid = 1'b0; blk_fixed = '0;
        model = 0;
        read_all(6);

        repeat (3) @(negedge clk);
        if (exq.size() != 0) begin
            total++; bad++;
            $display("FAIL R5: actual=%0d pending expected=0", exq.size());
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule